// File: doc/BRIEF.md
# ATA Register Window Decoder

This block sits between a simple memory-mapped slave port and a two-device ATA bus model. It claims a 4 KiB window and turns each host access into one strobe toward the ATA side: a task-file register access, a device-control write or alternate-status read, or a data-port transfer. Registers are laid out on a 16-byte stride, so the register index is taken from address bits 11 down to 4. Bits below and above that field play no part in the decode.

The access width comes from the byte enables. Host data is right-aligned on the bus: a byte travels in bits 7:0 and a halfword in bits 15:0. Halfword and word accesses are only meaningful at the data port. Data-port values are byte-reversed in both directions, because the host bus and the ATA bus have opposite byte orders. Accesses to indices that decode to nothing give fixed all-ones read data and leave the ATA side untouched. The device behaviour itself stays outside this block. The drive interrupt and the DMA interrupt pass straight through on separate outputs.

Every downstream strobe is registered. The strobe, register select and write data appear in the clock cycle after the host strobe. Read data is returned in that same following cycle.

Top module: `ata_window_decoder`

## Requirements
- R1: The register index is `bus_addr[11:4]`. Address bits 3:0 and all bits above 11 do not affect the decode.
- R2: A byte access at index 1 to 7 gives a one-cycle `tf_wr` or `tf_rd` pulse, with `tf_sel` equal to the index. Writes carry `bus_wdata[7:0]` on `reg_wdata`. Reads return `{24'h0, tf_rdata}`.
- R3: A byte access at index 8 or at index 22 writes the device-control register (`ctl_wr`, data on `reg_wdata`) or reads the alternate status (`alt_rd`, read data `{24'h0, alt_rdata}`).
- R4: A byte access at any other index, index 0 included, raises no downstream strobe. A read returns 32'h0000_00FF.
- R5: A halfword (`bus_be` 4'b0011 or 4'b1100) or a word (`bus_be` 4'b1111) at index 0 reaches the data port, with `dat_wide` = 1 for a word. The halfword is 2-byte swapped and the word is 4-byte swapped, in both directions. Example: a write of 16'hBEEF drives 16'hEFBE.
- R6: A halfword or word access at any nonzero index raises no strobe. A read returns 32'h0000_FFFF for a halfword or 32'hFFFF_FFFF for a word.
- R7: Each downstream strobe is high for exactly the one cycle after the host strobe, and read data is valid in that cycle. At most one downstream strobe is high at a time. A cycle with both `bus_rd` and `bus_wr` high does nothing.
- R8: A synchronous reset clears all downstream strobes and drives the read data to zero.
- R9: A byte-enable pattern other than one enabled byte, 4'b0011, 4'b1100 or 4'b1111 is no access: there is no strobe and the read data is zero.
- R10: `drv_irq` follows `drv_irq_in` and `dma_irq` follows `dma_irq_in`, with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 32 | Host byte address |
| bus_be | input | 4 | Host byte enables, which set the access width |
| bus_wdata | input | 32 | Host write data, right-aligned |
| bus_rd | input | 1 | Host read strobe |
| bus_wr | input | 1 | Host write strobe |
| bus_rdata | output | 32 | Read data, valid one cycle after `bus_rd` |
| tf_sel | output | 3 | Task-file register select |
| tf_rd | output | 1 | Task-file read strobe |
| tf_wr | output | 1 | Task-file write strobe |
| reg_wdata | output | 8 | Byte write data for the task-file and control registers |
| tf_rdata | input | 8 | Task-file read data from the ATA model |
| ctl_wr | output | 1 | Device-control write strobe |
| alt_rd | output | 1 | Alternate-status read strobe |
| alt_rdata | input | 8 | Alternate-status value |
| dat_rd | output | 1 | Data-port read strobe |
| dat_wr | output | 1 | Data-port write strobe |
| dat_wide | output | 1 | Data-port transfer is 32-bit (otherwise 16-bit) |
| dat_wdata | output | 32 | Byte-swapped data-port write value |
| dat_rdata | input | 32 | Data-port read value in ATA byte order |
| drv_irq_in | input | 1 | Drive interrupt from the ATA model |
| dma_irq_in | input | 1 | DMA interrupt source |
| drv_irq | output | 1 | Drive interrupt output |
| dma_irq | output | 1 | DMA interrupt output |

## Verification
The hardest cases to reach are those where the width and the index disagree. Examples are a halfword at a task-file index, a byte at the data-port index, and a word at the aliased control index 22, whose address sets bit 8. Each of these must fall through to the all-ones read value or to a dropped write, and must not leak onto a neighbouring strobe. The stimulus table pairs every index class with every width, including the odd byte-enable patterns and addresses with bits above the window set. After each access the bench also waits an idle cycle to show that the strobe has dropped. Directed tests then apply reset in the same cycle as a pending write, and apply read and write together.

// File: rtl/ata_window_decoder.sv
module ata_window_decoder #(
  parameter int ADDR_W      = 32,
  parameter int WIN_BITS    = 12,
  parameter int STRIDE_BITS = 4,
  parameter int TF_FIRST    = 1,
  parameter int TF_LAST     = 7,
  parameter int CTL_IDX_A   = 8,
  parameter int CTL_IDX_B   = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic [31:0]       bus_rdata,
  output logic [2:0]        tf_sel,
  output logic              tf_rd,
  output logic              tf_wr,
  output logic [7:0]        reg_wdata,
  input  logic [7:0]        tf_rdata,
  output logic              ctl_wr,
  output logic              alt_rd,
  input  logic [7:0]        alt_rdata,
  output logic              dat_rd,
  output logic              dat_wr,
  output logic              dat_wide,
  output logic [31:0]       dat_wdata,
  input  logic [31:0]       dat_rdata,
  input  logic              drv_irq_in,
  input  logic              dma_irq_in,
  output logic              drv_irq,
  output logic              dma_irq
);
  localparam int IDX_W  = WIN_BITS - STRIDE_BITS;
  localparam int NBYTES = 4;

  typedef enum logic [2:0] {
    RK_NONE, RK_TF, RK_ALT, RK_D16, RK_D32, RK_FF8, RK_FF16, RK_FF32
  } rkind_t;

  logic [IDX_W-1:0] idx;
  logic is_b, is_h, is_w;
  logic is_tf, is_ctl, is_dat;
  logic rd_ok, wr_ok;
  logic [31:0] wsw32, rsw32;
  logic [15:0] wsw16, rsw16;
  rkind_t rk_q, rk_d;
  logic unused_addr_bits;

  assign idx = bus_addr[WIN_BITS-1:STRIDE_BITS];
  assign unused_addr_bits = ^{bus_addr[ADDR_W-1:WIN_BITS], bus_addr[STRIDE_BITS-1:0]};

  always_comb begin
    is_b = 1'b0;
    is_h = 1'b0;
    is_w = 1'b0;
    case (bus_be)
      4'b0001, 4'b0010, 4'b0100, 4'b1000: is_b = 1'b1;
      4'b0011, 4'b1100:                   is_h = 1'b1;
      4'b1111:                            is_w = 1'b1;
      default: ;
    endcase
  end

  assign is_tf  = is_b && (idx >= IDX_W'(TF_FIRST)) && (idx <= IDX_W'(TF_LAST));
  assign is_ctl = is_b && ((idx == IDX_W'(CTL_IDX_A)) || (idx == IDX_W'(CTL_IDX_B)));
  assign is_dat = (is_h || is_w) && (idx == '0);
  assign rd_ok  = bus_rd && !bus_wr;
  assign wr_ok  = bus_wr && !bus_rd;

  for (genvar g = 0; g < NBYTES; g++) begin : g_swap
    assign wsw32[8*g +: 8] = bus_wdata[8*(NBYTES-1-g) +: 8];
    assign rsw32[8*g +: 8] = dat_rdata[8*(NBYTES-1-g) +: 8];
  end
  assign wsw16 = {bus_wdata[7:0], bus_wdata[15:8]};
  assign rsw16 = {dat_rdata[7:0], dat_rdata[15:8]};

  always_comb begin
    rk_d = RK_NONE;
    if (rd_ok) begin
      if (is_tf)               rk_d = RK_TF;
      else if (is_ctl)         rk_d = RK_ALT;
      else if (is_dat && is_h) rk_d = RK_D16;
      else if (is_dat && is_w) rk_d = RK_D32;
      else if (is_b)           rk_d = RK_FF8;
      else if (is_h)           rk_d = RK_FF16;
      else if (is_w)           rk_d = RK_FF32;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tf_rd     <= 1'b0;
      tf_wr     <= 1'b0;
      ctl_wr    <= 1'b0;
      alt_rd    <= 1'b0;
      dat_rd    <= 1'b0;
      dat_wr    <= 1'b0;
      dat_wide  <= 1'b0;
      tf_sel    <= '0;
      reg_wdata <= '0;
      dat_wdata <= '0;
      rk_q      <= RK_NONE;
    end else begin
      tf_rd  <= rd_ok && is_tf;
      tf_wr  <= wr_ok && is_tf;
      ctl_wr <= wr_ok && is_ctl;
      alt_rd <= rd_ok && is_ctl;
      dat_rd <= rd_ok && is_dat;
      dat_wr <= wr_ok && is_dat;
      rk_q   <= rk_d;
      if (is_tf)
        tf_sel <= idx[2:0];
      if (is_dat)
        dat_wide <= is_w;
      if (wr_ok && (is_tf || is_ctl))
        reg_wdata <= bus_wdata[7:0];
      if (wr_ok && is_dat)
        dat_wdata <= is_w ? wsw32 : {16'h0, wsw16};
    end
  end

  always_comb begin
    case (rk_q)
      RK_TF:   bus_rdata = {24'h0, tf_rdata};
      RK_ALT:  bus_rdata = {24'h0, alt_rdata};
      RK_D16:  bus_rdata = {16'h0, rsw16};
      RK_D32:  bus_rdata = rsw32;
      RK_FF8:  bus_rdata = 32'h0000_00FF;
      RK_FF16: bus_rdata = 32'h0000_FFFF;
      RK_FF32: bus_rdata = 32'hFFFF_FFFF;
      default: bus_rdata = 32'h0;
    endcase
  end

  assign drv_irq = drv_irq_in;
  assign dma_irq = dma_irq_in;
endmodule

module ata_window_decoder_chk #(
  parameter int ADDR_W      = 32,
  parameter int WIN_BITS    = 12,
  parameter int STRIDE_BITS = 4,
  parameter int TF_FIRST    = 1,
  parameter int TF_LAST     = 7,
  parameter int CTL_IDX_A   = 8,
  parameter int CTL_IDX_B   = 22
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [3:0]        bus_be,
  input logic [31:0]       bus_wdata,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [31:0]       bus_rdata,
  input logic [2:0]        tf_sel,
  input logic              tf_rd,
  input logic              tf_wr,
  input logic [7:0]        reg_wdata,
  input logic              ctl_wr,
  input logic              alt_rd,
  input logic              dat_rd,
  input logic              dat_wr,
  input logic              dat_wide,
  input logic [31:0]       dat_wdata
);
  localparam int IDX_W = WIN_BITS - STRIDE_BITS;
  logic [IDX_W-1:0] c_idx;
  logic [5:0] strb;
  logic c_byte_unmapped;

  assign c_idx = bus_addr[WIN_BITS-1:STRIDE_BITS];
  assign strb  = {tf_rd, tf_wr, ctl_wr, alt_rd, dat_rd, dat_wr};
  assign c_byte_unmapped = (c_idx < IDX_W'(TF_FIRST) || c_idx > IDX_W'(TF_LAST))
                        && c_idx != IDX_W'(CTL_IDX_A) && c_idx != IDX_W'(CTL_IDX_B);

  a_r7_single_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strb));

  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> (strb == 6'b0 && bus_rdata == 32'h0));

  a_r2_tf_write: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_rd && bus_be == 4'b0001 && c_idx >= IDX_W'(TF_FIRST) && c_idx <= IDX_W'(TF_LAST))
    |=> (tf_wr && tf_sel == $past(bus_addr[STRIDE_BITS+2:STRIDE_BITS]) && reg_wdata == $past(bus_wdata[7:0])));

  a_r4_byte_unmapped_read: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && bus_be == 4'b0001 && c_byte_unmapped) |=> (bus_rdata == 32'h0000_00FF && strb == 6'b0));

  a_r5_word_swap: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_rd && bus_be == 4'b1111 && c_idx == '0)
    |=> (dat_wr && dat_wide && dat_wdata == {$past(bus_wdata[7:0]), $past(bus_wdata[15:8]),
                                            $past(bus_wdata[23:16]), $past(bus_wdata[31:24])}));

  a_r6_wide_unmapped_read: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && bus_be == 4'b1111 && c_idx != '0) |=> (bus_rdata == 32'hFFFF_FFFF && strb == 6'b0));
endmodule

bind ata_window_decoder ata_window_decoder_chk #(
  .ADDR_W(ADDR_W), .WIN_BITS(WIN_BITS), .STRIDE_BITS(STRIDE_BITS),
  .TF_FIRST(TF_FIRST), .TF_LAST(TF_LAST), .CTL_IDX_A(CTL_IDX_A), .CTL_IDX_B(CTL_IDX_B)
) u_chk (.*);

// File: tb/test_ata_window_decoder.sv
module test_ata_window_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 22;

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] bus_addr;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata;
  logic        bus_rd, bus_wr;
  logic [31:0] bus_rdata;
  logic [2:0]  tf_sel;
  logic        tf_rd, tf_wr, ctl_wr, alt_rd, dat_rd, dat_wr, dat_wide;
  logic [7:0]  reg_wdata, tf_rdata, alt_rdata;
  logic [31:0] dat_wdata, dat_rdata;
  logic        drv_irq_in, dma_irq_in, drv_irq, dma_irq;

  int n_checks = 0;
  int n_fail = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign tf_rdata  = 8'hA0 | {5'b0, tf_sel};
  assign alt_rdata = 8'h5C;
  assign dat_rdata = 32'h1122_3344;

  ata_window_decoder i_ata_window_decoder (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata), .tf_sel(tf_sel),
    .tf_rd(tf_rd), .tf_wr(tf_wr), .reg_wdata(reg_wdata), .tf_rdata(tf_rdata),
    .ctl_wr(ctl_wr), .alt_rd(alt_rd), .alt_rdata(alt_rdata), .dat_rd(dat_rd),
    .dat_wr(dat_wr), .dat_wide(dat_wide), .dat_wdata(dat_wdata), .dat_rdata(dat_rdata),
    .drv_irq_in(drv_irq_in), .dma_irq_in(dma_irq_in), .drv_irq(drv_irq), .dma_irq(dma_irq)
  );

  // fields: wr[93] be[92:89] addr[88:73] wdata[72:41] strb[40:35] idx[34:32] val[31:0]
  // strb order: tf_rd tf_wr ctl_wr alt_rd dat_rd dat_wr
  localparam logic [93:0] VEC [NVEC] = '{
    {1'b1, 4'h1, 16'h0010, 32'h0000_005A, 6'b010000, 3'd1, 32'h0000_005A}, // R2
    {1'b1, 4'h1, 16'h0075, 32'h0000_003C, 6'b010000, 3'd7, 32'h0000_003C}, // R2 R1
    {1'b0, 4'h1, 16'h0030, 32'h0,         6'b100000, 3'd3, 32'h0000_00A3}, // R2
    {1'b1, 4'h1, 16'h0080, 32'h0000_0006, 6'b001000, 3'd0, 32'h0000_0006}, // R3
    {1'b1, 4'h1, 16'h0160, 32'h0000_0002, 6'b001000, 3'd0, 32'h0000_0002}, // R3
    {1'b0, 4'h1, 16'h0080, 32'h0,         6'b000100, 3'd0, 32'h0000_005C}, // R3
    {1'b0, 4'h1, 16'h0168, 32'h0,         6'b000100, 3'd0, 32'h0000_005C}, // R3
    {1'b0, 4'h1, 16'h0000, 32'h0,         6'b000000, 3'd0, 32'h0000_00FF}, // R4
    {1'b0, 4'h1, 16'h0090, 32'h0,         6'b000000, 3'd0, 32'h0000_00FF}, // R4
    {1'b1, 4'h1, 16'h00F0, 32'h0000_0077, 6'b000000, 3'd0, 32'h0},         // R4
    {1'b1, 4'h3, 16'h0000, 32'h0000_BEEF, 6'b000001, 3'd0, 32'h0000_EFBE}, // R5
    {1'b1, 4'hF, 16'h0004, 32'h1234_5678, 6'b000001, 3'd0, 32'h7856_3412}, // R5
    {1'b0, 4'h3, 16'h0000, 32'h0,         6'b000010, 3'd0, 32'h0000_4433}, // R5
    {1'b0, 4'hF, 16'h000C, 32'h0,         6'b000010, 3'd0, 32'h4433_2211}, // R5
    {1'b0, 4'h3, 16'h0010, 32'h0,         6'b000000, 3'd0, 32'h0000_FFFF}, // R6
    {1'b0, 4'hF, 16'h0080, 32'h0,         6'b000000, 3'd0, 32'hFFFF_FFFF}, // R6
    {1'b1, 4'hF, 16'h0010, 32'hAAAA_5555, 6'b000000, 3'd0, 32'h0},         // R6
    {1'b1, 4'hC, 16'h0160, 32'h0000_1234, 6'b000000, 3'd0, 32'h0},         // R6
    {1'b0, 4'h6, 16'h0000, 32'h0,         6'b000000, 3'd0, 32'h0},         // R9
    {1'b1, 4'h5, 16'h0010, 32'h0000_0011, 6'b000000, 3'd0, 32'h0},         // R9
    {1'b0, 4'h8, 16'h1070, 32'h0,         6'b100000, 3'd7, 32'h0000_00A7}, // R1
    {1'b1, 4'h1, 16'hF080, 32'h0000_000E, 6'b001000, 3'd0, 32'h0000_000E}  // R1
  };

  function automatic logic [5:0] strobes();
    return {tf_rd, tf_wr, ctl_wr, alt_rd, dat_rd, dat_wr};
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    bus_rd = 1'b0; bus_wr = 1'b0; bus_be = 4'h0; bus_addr = '0; bus_wdata = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; drv_irq_in = 1'b0; dma_irq_in = 1'b0;
    idle();
    repeat (3) @(negedge clk);
    check(strobes() == 6'b0, "R8 reset strobes", {26'h0, strobes()}, 32'h0);
    check(bus_rdata == 32'h0, "R8 reset rdata", bus_rdata, 32'h0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      bus_wr = VEC[i][93];
      bus_rd = !VEC[i][93];
      bus_be = VEC[i][92:89];
      bus_addr = {16'h0, VEC[i][88:73]};
      bus_wdata = VEC[i][72:41];
      @(negedge clk);
      check(strobes() == VEC[i][40:35], $sformatf("R2-R6/R9 strobes vec %0d", i),
            {26'h0, strobes()}, {26'h0, VEC[i][40:35]});
      if (VEC[i][39] || VEC[i][40])
        check(tf_sel == VEC[i][34:32], $sformatf("R2 tf_sel vec %0d", i), {29'h0, tf_sel}, {29'h0, VEC[i][34:32]});
      if (VEC[i][93]) begin
        if (VEC[i][35]) begin
          check(dat_wdata == VEC[i][31:0], $sformatf("R5 dat_wdata vec %0d", i), dat_wdata, VEC[i][31:0]);
          check(dat_wide == (VEC[i][92:89] == 4'hF), $sformatf("R5 dat_wide vec %0d", i),
                {31'h0, dat_wide}, {31'h0, VEC[i][92:89] == 4'hF});
        end else if (VEC[i][40:35] != 6'b0)
          check(reg_wdata == VEC[i][7:0], $sformatf("R2/R3 reg_wdata vec %0d", i), {24'h0, reg_wdata}, VEC[i][31:0]);
      end else begin
        check(bus_rdata == VEC[i][31:0], $sformatf("R7 rdata vec %0d", i), bus_rdata, VEC[i][31:0]);
        if (VEC[i][36])
          check(dat_wide == (VEC[i][92:89] == 4'hF), $sformatf("R5 dat_wide rd vec %0d", i),
                {31'h0, dat_wide}, {31'h0, VEC[i][92:89] == 4'hF});
      end
      idle();
      @(negedge clk);
      check(strobes() == 6'b0, $sformatf("R7 strobe one cycle vec %0d", i), {26'h0, strobes()}, 32'h0);
    end

    // R7: read and write together do nothing
    bus_rd = 1'b1; bus_wr = 1'b1; bus_be = 4'h1; bus_addr = 32'h10; bus_wdata = 32'h99;
    @(negedge clk);
    check(strobes() == 6'b0, "R7 rd+wr strobes", {26'h0, strobes()}, 32'h0);
    check(bus_rdata == 32'h0, "R7 rd+wr rdata", bus_rdata, 32'h0);
    idle();
    @(negedge clk);

    // R8: reset in the same cycle as a write
    rst = 1'b1; bus_wr = 1'b1; bus_be = 4'hF; bus_addr = 32'h0; bus_wdata = 32'hCAFE_F00D;
    @(negedge clk);
    check(strobes() == 6'b0, "R8 reset beats write", {26'h0, strobes()}, 32'h0);
    rst = 1'b0;
    idle();
    @(negedge clk);

    // R10: interrupt pass-through
    drv_irq_in = 1'b1; dma_irq_in = 1'b0;
    #1;
    check(drv_irq == 1'b1 && dma_irq == 1'b0, "R10 irq drv", {30'h0, drv_irq, dma_irq}, 32'h2);
    drv_irq_in = 1'b0; dma_irq_in = 1'b1;
    #1;
    check(drv_irq == 1'b0 && dma_irq == 1'b1, "R10 irq dma", {30'h0, drv_irq, dma_irq}, 32'h1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule